// File: doc/BRIEF.md
# One-Wire Temperature Sensor Reader

This block reads a single digital temperature sensor on a one-wire bus. It has no separate bus master: it builds every bus slot itself from a microsecond tick, which it gets by dividing the system clock. The pad drives the open-drain bus low whenever `dq_oe` is high and otherwise leaves it to the pull-up. The bus level comes back on `dq_i`.

A request on `rd_en` while the block is idle starts a fixed script. The block sends a bus reset and checks for a presence reply. It then writes the skip-ROM, start-conversion and read-scratchpad commands, with the conversion wait placed before the last of these. Next it shifts in twelve raw temperature bits. The whole-degree part of the reading appears on `temp_c` and `ready` goes high. If no device answers the reset, the block raises `no_device` and returns to idle.

Top module: `ow_temp_reader`

## Requirements
- R1: After reset, `dq_oe`, `ready` and `no_device` are 0 and `temp_c` is 0.
- R2: A transaction starts only when `rd_en` is high in idle. Starting clears `ready` and `no_device` one cycle after `rd_en` is sampled.
- R3: The reset phase lasts RESET_US microseconds, exactly RESET_US*CLKS_PER_US cycles. `dq_oe` is high for the first half of it. The first command slot starts when the phase ends.
- R4: The device is present when `dq_i` is 0 at the last microsecond of the reset phase. Otherwise `no_device` goes to 1, `ready` stays 0 and no slot is issued.
- R5: The command bytes go out in this order: 0xCC, then 0x44, then 0xBE. Each is sent least significant bit first, so there are 24 write slots in total.
- R6: Every slot lasts exactly SLOT_US (65) microseconds. A 0 bit holds `dq_oe` high for 60 µs. A 1 bit holds it high for 2 µs.
- R7: Between the last slot of 0x44 and the first slot of 0xBE the block inserts a wait of exactly CONV_US microseconds.
- R8: Twelve read slots follow the commands. Each one holds `dq_oe` high for 2 µs and samples `dq_i` at the end of the 12th microsecond of the slot.
- R9: The twelve bits read, least significant first, form a 12-bit two's-complement raw value. `temp_c` is that value shifted right arithmetically by 4, keeping the low 7 bits. `ready` then goes to 1.
- R10: `rd_en` has no effect while a transaction is running: no second bus reset follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Request a temperature reading |
| dq_i | input | 1 | Sampled one-wire bus level |
| dq_oe | output | 1 | Pull the bus low when 1 |
| temp_c | output | 7 | Signed whole-degree temperature |
| ready | output | 1 | A new reading is held on `temp_c` |
| no_device | output | 1 | The last reset got no presence reply |

## Verification
The bench models the sensor from the bus side. It measures every low pulse and every slot spacing in cycles. This catches a delay counter that adds a cycle or two on reload, which would stretch the reset phase, the slots or the conversion wait. It decodes the written bits from pulse widths, so a swapped byte order or an MSB-first shift shows up as a wrong command byte. The sensor releases its read pulses shortly before or after the 12 µs point, so a sampling point that is too early or too late returns a corrupted value. Negative raw readings with fraction bits set check that the shift floors towards minus infinity. A missing device must end in `no_device` with a quiet bus. A request made mid-transaction must not trigger a second reset.

// File: rtl/ow_temp_reader.sv
module ow_temp_reader #(
  parameter int CLKS_PER_US = 50,
  parameter int RESET_US    = 960,
  parameter int SLOT_US     = 65,
  parameter int CONV_US     = 750000,
  parameter int W0_LOW_US   = 60,
  parameter int W1_LOW_US   = 2,
  parameter int SAMPLE_US   = 12,
  parameter int RAW_BITS    = 12,
  parameter int FRAC_BITS   = 4,
  parameter int OUT_W       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             dq_i,
  output logic             dq_oe,
  output logic [OUT_W-1:0] temp_c,
  output logic             ready,
  output logic             no_device
);
  localparam int DIV_W  = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam int MAXLEN = (CONV_US > RESET_US) ? CONV_US : RESET_US;
  localparam int US_W   = $clog2(MAXLEN + 1);
  localparam int RB_W   = $clog2(RAW_BITS);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_WR, S_CONV, S_RD} st_t;
  st_t st;

  logic [DIV_W-1:0]    div;
  logic [US_W-1:0]     us, len;
  logic [2:0]          bit_i;
  logic [1:0]          byte_i;
  logic [RB_W-1:0]     rbit;
  logic [RAW_BITS-1:0] raw;
  logic [7:0]          cmd;
  logic                tick, last, wbit;

  function automatic logic [OUT_W-1:0] whole_deg(input logic [RAW_BITS-1:0] r);
    logic signed [RAW_BITS-1:0] s;
    s = $signed(r) >>> FRAC_BITS;
    return s[OUT_W-1:0];
  endfunction

  assign tick = div == DIV_W'(CLKS_PER_US - 1);
  assign len  = (st == S_RST) ? US_W'(RESET_US) : (st == S_CONV) ? US_W'(CONV_US) : US_W'(SLOT_US);
  assign last = tick && us == len - US_W'(1);
  assign cmd  = (byte_i == 2'd0) ? 8'hCC : (byte_i == 2'd1) ? 8'h44 : 8'hBE;
  assign wbit = cmd[bit_i];

  assign dq_oe = (st == S_RST && us < US_W'(RESET_US / 2)) ||
                 (st == S_WR  && us < (wbit ? US_W'(W1_LOW_US) : US_W'(W0_LOW_US))) ||
                 (st == S_RD  && us < US_W'(W1_LOW_US));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; us <= '0; bit_i <= '0; byte_i <= '0;
      rbit <= '0; raw <= '0; temp_c <= '0; ready <= 1'b0; no_device <= 1'b0;
    end else begin
      div <= (st == S_IDLE || tick) ? '0 : div + DIV_W'(1);
      if (st == S_IDLE || last) us <= '0;
      else if (tick)            us <= us + US_W'(1);
      case (st)
        S_IDLE: if (rd_en) begin
          st <= S_RST; ready <= 1'b0; no_device <= 1'b0;
        end
        S_RST: if (last) begin
          if (!dq_i) begin
            st <= S_WR; bit_i <= '0; byte_i <= '0;
          end else begin
            st <= S_IDLE; no_device <= 1'b1;
          end
        end
        S_WR: if (last) begin
          bit_i <= bit_i + 3'd1;
          if (bit_i == 3'd7) begin
            byte_i <= byte_i + 2'd1;
            if (byte_i == 2'd1) st <= S_CONV;
            else if (byte_i == 2'd2) begin
              st <= S_RD; rbit <= '0;
            end
          end
        end
        S_CONV: if (last) st <= S_WR;
        S_RD: begin
          if (tick && us == US_W'(SAMPLE_US - 1)) raw <= {dq_i, raw[RAW_BITS-1:1]};
          if (last) begin
            rbit <= rbit + RB_W'(1);
            if (rbit == RB_W'(RAW_BITS - 1)) begin
              st <= S_IDLE; ready <= 1'b1; temp_c <= whole_deg(raw);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_temp_reader_chk.sv
module ow_temp_reader_chk #(
  parameter int MAX_LOW = 24000,
  parameter int OUT_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             dq_oe,
  input logic [OUT_W-1:0] temp_c,
  input logic             ready,
  input logic             no_device
);
  localparam int LW = $clog2(MAX_LOW + 2);
  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)     low_run <= '0;
    else if (dq_oe) low_run <= (low_run == LW'(MAX_LOW + 1)) ? low_run : low_run + LW'(1);
    else            low_run <= '0;
  end

  // R3, R6: no bus-low pulse outlasts the reset half-phase
  a_r6_low_bounded: assert property (@(posedge clk) disable iff (!rst_n) low_run <= LW'(MAX_LOW));

  // R2: a request taken while a reading is held clears ready
  a_r2_ready_clears: assert property (@(posedge clk) disable iff (!rst_n) ready && rd_en |=> !ready);

  // R4: a missing device leaves the bus released and no reading
  a_r4_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n) no_device |-> !dq_oe && !ready);

  // R9: the result only changes as ready rises
  a_r9_temp_with_ready: assert property (@(posedge clk) disable iff (!rst_n) !$stable(temp_c) |-> $rose(ready));

  // R1: outputs are idle coming out of reset
  a_r1_reset_idle: assert property (@(posedge clk) $rose(rst_n) |-> !dq_oe && !ready && !no_device);
endmodule

bind ow_temp_reader ow_temp_reader_chk #(.MAX_LOW((RESET_US / 2) * CLKS_PER_US), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .dq_oe(dq_oe),
  .temp_c(temp_c), .ready(ready), .no_device(no_device)
);

// File: tb/tb_ow_temp_reader.sv
module tb_ow_temp_reader;
  localparam int CLK  = 4;
  localparam int CONV = 300;

  logic clk = 0, rst_n = 0, rd_en = 0, dq_i = 1;
  logic dq_oe, ready, no_device;
  logic [6:0] temp_c;

  ow_temp_reader #(.CLKS_PER_US(CLK), .CONV_US(CONV)) dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .dq_i(dq_i), .dq_oe(dq_oe),
    .temp_c(temp_c), .ready(ready), .no_device(no_device));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, cur_start = 0, rst_start = 0, rst_len = 0, rst_seen = 0, slot_n = 0;
  int starts[0:39], lens[0:39];
  int sens_until = 0;
  logic sens_low = 0, oe_q = 0, present = 1;
  logic [11:0] drive_raw = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (dq_oe && !oe_q) begin
      cur_start = cyc;
      sens_low = 0;
      if (slot_n >= 24 && slot_n < 36) begin
        sens_low = 1;
        sens_until = cyc + (drive_raw[slot_n-24] ? 10 : 13) * CLK;
      end
    end
    if (!dq_oe && oe_q) begin
      if (cyc - cur_start >= 100 * CLK) begin
        rst_len = cyc - cur_start; rst_start = cur_start; rst_seen++; slot_n = 0;
        if (present) begin sens_low = 1; sens_until = cyc + 100000; end
      end else if (slot_n < 40) begin
        starts[slot_n] = cur_start; lens[slot_n] = cyc - cur_start; slot_n++;
      end
    end
    if (sens_low && cyc >= sens_until) sens_low = 0;
    oe_q = dq_oe;
    dq_i = !(dq_oe || sens_low);
  end

  function automatic logic [6:0] exp_temp(input logic [11:0] r);
    int v;
    v = r;
    if (v >= 2048) v -= 4096;
    v = v >>> 4;
    return v[6:0];
  endfunction

  task automatic start_req();
    rst_seen = 0; slot_n = 0;
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    check(!ready && !no_device, "R2 flags cleared on start", {ready, no_device}, 0);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 30000 && !ready && !no_device; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check(!dq_oe && !ready && !no_device && temp_c == 0, "R1 reset outputs",
          {dq_oe, ready, no_device, temp_c}, 0);
  endtask

  task automatic t_read(input logic [11:0] r, input int busy_poke);
    logic [7:0] b [3];
    int bad_len = 0, bad_sp = 0, bad_rd = 0, conv_gap;
    present = 1; drive_raw = r;
    start_req();
    if (busy_poke > 0) begin
      repeat (busy_poke) @(negedge clk);
      rd_en = 1; @(negedge clk); rd_en = 0;
    end
    wait_done();
    check(ready && !no_device, "R9 ready after read", {ready, no_device}, 2);
    check(temp_c == exp_temp(r), "R9 temperature", temp_c, exp_temp(r));
    check(rst_len == 480 * CLK, "R3 reset low width", rst_len, 480 * CLK);
    check(starts[0] - rst_start == 960 * CLK, "R3 reset phase length", starts[0] - rst_start, 960 * CLK);
    check(slot_n == 36, "R5 slot count", slot_n, 36);
    for (int i = 0; i < 24; i++) begin
      b[i/8][i%8] = (lens[i] == 2 * CLK);
      if (lens[i] != 2 * CLK && lens[i] != 60 * CLK) bad_len++;
    end
    check(b[0] == 8'hCC && b[1] == 8'h44 && b[2] == 8'hBE, "R5 command bytes",
          {b[0], b[1], b[2]}, 24'hCC44BE);
    check(bad_len == 0, "R6 write pulse widths", bad_len, 0);
    for (int i = 0; i < 35; i++)
      if (i != 15 && starts[i+1] - starts[i] != 65 * CLK) bad_sp++;
    check(bad_sp == 0, "R6 slot spacing", bad_sp, 0);
    conv_gap = starts[16] - starts[15];
    check(conv_gap == (65 + CONV) * CLK, "R7 conversion wait", conv_gap, (65 + CONV) * CLK);
    for (int i = 24; i < 36; i++) if (lens[i] != 2 * CLK) bad_rd++;
    check(bad_rd == 0, "R8 read pulse widths", bad_rd, 0);
    if (busy_poke > 0) begin
      repeat (3000) @(negedge clk);
      check(rst_seen == 1 && !dq_oe && ready, "R10 request while busy ignored", rst_seen, 1);
    end
  endtask

  task automatic t_absent();
    present = 0;
    start_req();
    wait_done();
    check(no_device && !ready, "R4 absent device flagged", {no_device, ready}, 2);
    repeat (2000) @(negedge clk);
    check(rst_seen == 1 && slot_n == 0, "R4 no slots after absence", slot_n, 0);
    present = 1;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_read(12'h195, 0);
    t_read(12'hF58, 0);
    t_absent();
    t_read(12'h000, 0);
    t_read(12'hFFF, 3000);
    t_read(12'h3F0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule